// File: doc/BRIEF.md
# Phase-Accumulating Waveform Synthesizer

This block synthesizes one signed 16-bit sample per clock for a function generator. A 48-bit phase register advances on every clock by a programmable tuning word. The top 14 bits of the phase register form a position inside one waveform period of 16,384 points. The output frequency is the tuning word times the clock rate divided by 2^48. The output does not play table points one after another: a step larger than one point skips positions, and a smaller step repeats them.

Four shapes are computed directly from the phase position: a sine, a square, a ramp and a triangle. The sine is an approximation built from two parabolas. A fifth shape comes from a user-writable period table. That table holds 1,024 entries, and each entry covers 16 consecutive phase positions. Changing the tuning word only changes the step size. The phase carries on from where it was, so a retune never produces a jump in phase. A synchronous phase-clear input gives a known starting phase.

Top module: `dds_wavegen`

## Requirements
- R1: On each clock that is not a phase clear, the phase register adds the registered tuning word modulo 2^48. The position is phase[47:34]. A step larger than 2^34 skips positions, and a negative step such as all-ones runs the phase backwards.
- R2: When `ftw_wr` is high at a clock edge, `ftw_in` is captured at that edge. The captured word first adds to the phase at the following edge.
- R3: Loading a new tuning word never alters the phase register. The output after a retune continues from the phase already reached.
- R4: When `phase_clr` is high at an edge, the phase register becomes zero, whatever the tuning word is.
- R5: `sample` is registered and is a function of the phase held before the edge. It is 16-bit two's complement. `wave_sel` selects the shape: 0 sine, 1 square, 2 ramp, 3 triangle, 4 user table. Codes 5 to 7 give 0.
- R6: Sine. Let h be position mod 8192. Then v = floor(h*(8191-h)/512). The output is v for positions below 8192 and -v for positions from 8192 up.
- R7: Square. The output is 32767 for positions below 8192 and -32768 for positions from 8192 up.
- R8: Ramp. The output is position*4 - 32768.
- R9: Triangle. Let h be position mod 8192. The output is h*8 - 32768 in the first half of the period and (8191-h)*8 - 32768 in the second half.
- R10: User. The output is the table entry at index position/16 (phase[47:38]). When `tab_we` is high, `tab_data` is written to entry `tab_addr` at that edge.
- R11: A table write is ignored while `wave_sel` is 4. The entry keeps its previous value.
- R12: While reset is asserted (active-low, asynchronous), the phase register, the tuning word and `sample` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clr | input | 1 | Synchronous clear of the phase register |
| ftw_wr | input | 1 | Load strobe for the tuning word |
| ftw_in | input | 48 | New tuning word |
| wave_sel | input | 3 | Shape select |
| tab_we | input | 1 | User table write enable |
| tab_addr | input | 10 | User table write index |
| tab_data | input | 16 | User table write value |
| sample | output | 16 | Signed output sample |

## Verification
The hardest case to reach from the ports is a write to the user table that must be dropped while that table is playing. The drop only shows once the phase later sweeps past the entry that was written. The stimulus first fills the whole table and then selects it. It then writes over several entries and sweeps the phase across all 1,024 entries twice with a step of 2^37, so every entry is read back at the output. Phase continuity across a retune is checked in a similar way: the ramp output gives the phase directly, so a retune in the middle of a ramp must continue from the phase already reached.

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
  parameter int ACC_W = 48,
  parameter int AW    = 14,
  parameter int DW    = 16,
  parameter int UAW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_clr,
  input  logic             ftw_wr,
  input  logic [ACC_W-1:0] ftw_in,
  input  logic [2:0]       wave_sel,
  input  logic             tab_we,
  input  logic [UAW-1:0]   tab_addr,
  input  logic [DW-1:0]    tab_data,
  output logic [DW-1:0]    sample
);
  localparam int SSH = 2*AW - 3 - DW;
  localparam int PW  = 2*AW - 2;
  localparam logic [2:0] SEL_SINE = 3'd0, SEL_SQR = 3'd1, SEL_RAMP = 3'd2,
                         SEL_TRI = 3'd3, SEL_USER = 3'd4;

  logic [ACC_W-1:0] acc, ftw_q;
  logic [DW-1:0]    umem [2**UAW];
  logic [DW-1:0]    shape;

  wire [AW-1:0] pos = acc[ACC_W-1 -: AW];
  wire          hi  = pos[AW-1];
  wire [AW-2:0] h   = pos[AW-2:0];
  wire [AW-2:0] t   = hi ? ~h : h;
  wire [PW-1:0] prod = {{(AW-1){1'b0}}, h} * {{(AW-1){1'b0}}, ~h};
  wire [DW-1:0] smag = DW'(prod >> SSH);

  wire [DW-1:0] sine_v = hi ? -smag : smag;
  wire [DW-1:0] sqr_v  = hi ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  wire [DW-1:0] ramp_v = {~pos[AW-1], pos[AW-2:0], {(DW-AW){1'b0}}};
  wire [DW-1:0] tri_v  = {~t[AW-2], t[AW-3:0], {(DW-AW+1){1'b0}}};
  wire [DW-1:0] usr_v  = umem[pos[AW-1 -: UAW]];

  always_comb begin
    case (wave_sel)
      SEL_SINE: shape = sine_v;
      SEL_SQR:  shape = sqr_v;
      SEL_RAMP: shape = ramp_v;
      SEL_TRI:  shape = tri_v;
      SEL_USER: shape = usr_v;
      default:  shape = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      ftw_q  <= '0;
      sample <= '0;
    end else begin
      acc    <= phase_clr ? '0 : acc + ftw_q;
      sample <= shape;
      if (ftw_wr) ftw_q <= ftw_in;
    end
  end

  always_ff @(posedge clk) begin
    if (tab_we && wave_sel != SEL_USER) umem[tab_addr] <= tab_data;
  end

  a_r2_ftw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ftw_wr |=> $stable(ftw_q));
  a_r2_ftw_load: assert property (@(posedge clk) disable iff (!rst_n)
    ftw_wr |=> ftw_q == $past(ftw_in));
  a_r4_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> acc == '0);
  a_r7_square_levels: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sel == SEL_SQR |=> (sample == {1'b0, {(DW-1){1'b1}}} || sample == {1'b1, {(DW-1){1'b0}}}));
  a_r11_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (tab_we && wave_sel == SEL_USER) |=> umem[$past(tab_addr)] == $past(umem[tab_addr]));
  a_r5_idle_codes: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sel > SEL_USER |=> sample == '0);
endmodule

// File: tb/dds_wavegen_bench.sv
module dds_wavegen_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, phase_clr = 0, ftw_wr = 0, tab_we = 0;
  logic [47:0] ftw_in = '0;
  logic [2:0]  wave_sel = 3'd0;
  logic [9:0]  tab_addr = '0;
  logic [15:0] tab_data = '0;
  logic [15:0] sample;

  dds_wavegen u_dds_wavegen (.clk(clk), .rst_n(rst_n), .phase_clr(phase_clr),
    .ftw_wr(ftw_wr), .ftw_in(ftw_in), .wave_sel(wave_sel), .tab_we(tab_we),
    .tab_addr(tab_addr), .tab_data(tab_data), .sample(sample));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R12";
  logic [47:0] m_acc = '0, m_ftw = '0;
  int m_mem [1024];
  int m_exp = 0;
  bit comparing = 0;

  function automatic int shape_of(logic [47:0] ph, logic [2:0] sel);
    int p, hh, v;
    p  = int'(ph[47:34]);
    hh = p % 8192;
    case (sel)
      3'd0: begin v = (hh * (8191 - hh)) / 512; return (p < 8192) ? v : -v; end
      3'd1: return (p < 8192) ? 32767 : -32768;
      3'd2: return p * 4 - 32768;
      3'd3: return (p < 8192) ? hh * 8 - 32768 : (8191 - hh) * 8 - 32768;
      3'd4: return m_mem[p / 16];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_ftw = '0; m_exp = 0;
    end else begin
      m_exp = shape_of(m_acc, wave_sel);
      m_acc = phase_clr ? 48'd0 : m_acc + m_ftw;
      if (ftw_wr) m_ftw = ftw_in;
      if (tab_we && wave_sel != 3'd4) m_mem[tab_addr] = $signed(tab_data);
    end
  end

  always @(negedge clk) if (comparing) begin
    checks++;
    if (int'($signed(sample)) != m_exp) begin
      failures++;
      $display("FAIL %s: sample=%0d expected=%0d", tag, $signed(sample), m_exp);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_ftw(logic [47:0] w);
    @(negedge clk); ftw_in = w; ftw_wr = 1;
    @(negedge clk); ftw_wr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    checks++;
    if (sample !== 16'd0) begin
      failures++;
      $display("FAIL R12: sample=%0h expected=0 in reset", sample);
    end
    @(negedge clk); rst_n = 1;
    comparing = 1;

    tag = "R10 table fill";
    for (int i = 0; i < 1024; i++) begin
      tab_we = 1; tab_addr = 10'(i); tab_data = 16'((i * 37 - 20000) & 16'hffff);
      @(negedge clk);
    end
    tab_we = 0;

    tag = "R2 tuning load";
    load_ftw(48'h0000_0412_3456);
    step(5);
    tag = "R6 sine";
    load_ftw(48'h0013_0000_0001);
    step(400);
    tag = "R7 square";
    wave_sel = 3'd1; step(200);
    tag = "R8 ramp skipping";
    wave_sel = 3'd2; load_ftw(48'h0123_4567_89AB); step(300);
    tag = "R3 retune";
    load_ftw(48'h0000_7000_0000); step(40);
    load_ftw(48'h0777_0000_0000); step(40);
    tag = "R1 wrap backward";
    load_ftw(48'hFFFF_FFFF_FFFF); step(30);
    load_ftw(48'hFF00_0000_0001); step(200);
    tag = "R9 triangle";
    wave_sel = 3'd3; load_ftw(48'h00AB_CDEF_0123); step(300);
    tag = "R4 phase clear";
    @(negedge clk); phase_clr = 1;
    @(negedge clk); phase_clr = 0;
    step(10);
    phase_clr = 1; ftw_wr = 1; ftw_in = 48'h0010_0000_0000;
    @(negedge clk); phase_clr = 0; ftw_wr = 0;
    step(20);
    tag = "R5 unused codes";
    wave_sel = 3'd6; step(20);
    wave_sel = 3'd7; step(5);
    tag = "R10 user play";
    wave_sel = 3'd4;
    @(negedge clk); phase_clr = 1;
    @(negedge clk); phase_clr = 0;
    load_ftw(48'h0020_0000_0000);
    step(300);
    tag = "R11 locked writes";
    for (int i = 0; i < 8; i++) begin
      tab_we = 1; tab_addr = 10'(i * 111); tab_data = 16'h1234;
      @(negedge clk);
    end
    tab_we = 0;
    step(2100);
    tag = "R10 rewrite";
    wave_sel = 3'd0;
    tab_we = 1; tab_addr = 10'd5; tab_data = 16'h7ABC;
    @(negedge clk); tab_we = 0;
    wave_sel = 3'd4; step(2100);

    comparing = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule